// File: doc/BRIEF.md
# DRAM Row-Buffer-Aware Command Scheduler

This block sits between request sources and a DRAM command bus. Each incoming request already carries its bank, row and column fields and a read/write flag. The block holds the pending requests in a small queue and keeps a record of which row, if any, each bank currently holds open. Every cycle it selects at most one pending request and offers the next command that request needs: a precharge, an activate, or the column access itself.

Requests are not served in arrival order. A request whose row is already open in its bank (a row hit) needs only its column command, so such requests are preferred and bank row buffers stay useful. A request to a closed bank needs an activate and then the column command. A request to a bank with a different row open (a conflict) needs a precharge, an activate, and the column command. Each bank carries a short recovery counter so that commands to it keep a minimum gap after an activate or a precharge.

Top module: `dram_sched`

## Requirements
- R1: After reset the queue is empty, `req_ready` is 1, `cmd_valid` is 0 and every bank is closed, so the first command to any bank is an activate.
- R2: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge; `req_ready` is 0 exactly when the queue holds QDEPTH (default 8) requests.
- R3: A request whose row is open in its bank is served by a single column command, `cmd_op` = 3.
- R4: A request to a closed bank is served by an activate, `cmd_op` = 2, followed later by its column command.
- R5: A request to a bank holding another row is served by a precharge (`cmd_op` = 1), then an activate, then its column command.
- R6: After an activate or a precharge to a bank is accepted, no command to that bank is offered during the next T_RCD (activate) or T_RP (precharge) cycles, both 3 by default; other banks are not affected.
- R7: Among requests whose next command is legal, the oldest row hit is chosen; if no hit is ready, the oldest request with a legal next command is chosen. `cmd_bank`, `cmd_row` and `cmd_col` carry that request's fields for every command type.
- R8: At most one command is accepted per cycle, a command is accepted only when `cmd_valid` and `cmd_ready` are both 1, and a request leaves the queue only when its column command is accepted; while `cmd_ready` is 0 no request and no bank state is lost.
- R9: On a column command, `cmd_write` equals the request's flag (1 write, 0 read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has a free slot |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | BANK_W (2) | Request bank |
| req_row | input | ROW_W (8) | Request row |
| req_col | input | COL_W (6) | Request column |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | Command bus accepts the offered command |
| cmd_op | output | 2 | 1 precharge, 2 activate, 3 column access |
| cmd_write | output | 1 | Read/write flag of the selected request |
| cmd_bank | output | BANK_W (2) | Bank of the command |
| cmd_row | output | ROW_W (8) | Row of the selected request |
| cmd_col | output | COL_W (6) | Column of the selected request |

## Verification
The assertions watch, every cycle, the command stream against a bank state rebuilt from accepted commands alone: column commands only to the open row, activates only to closed banks, precharges only to open banks, the recovery gap per bank, and queue occupancy against `req_ready` and `cmd_valid`. Which request wins when several are legal, the oldest-hit-first ordering, and the survival of requests and timers through long stalls of `cmd_ready` can only be shown by the bench, whose reference model predicts each offered command from arrival order and per-bank state and compares it cycle by cycle.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PRE  = 2'd1,
    OP_ACT  = 2'd2,
    OP_COL  = 2'd3
  } cmd_op_e;
endpackage

// File: rtl/dram_sched_queue.sv
module dram_sched_queue #(
  parameter int QDEPTH = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int IDX_W  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ins_en,
  input  logic                             ins_write,
  input  logic [BANK_W-1:0]                ins_bank,
  input  logic [ROW_W-1:0]                 ins_row,
  input  logic [COL_W-1:0]                 ins_col,
  input  logic                             rm_en,
  input  logic [IDX_W-1:0]                 rm_idx,
  output logic                             full,
  output logic [QDEPTH-1:0]                q_valid,
  output logic [QDEPTH-1:0]                q_write,
  output logic [QDEPTH-1:0][BANK_W-1:0]    q_bank,
  output logic [QDEPTH-1:0][ROW_W-1:0]     q_row,
  output logic [QDEPTH-1:0][COL_W-1:0]     q_col,
  output logic [QDEPTH-1:0][IDX_W-1:0]     q_age
);
  localparam int CNT_W = IDX_W + 1;

  logic                         free_found;
  logic [IDX_W-1:0]             free_idx;
  logic [CNT_W-1:0]             occupied;
  logic [QDEPTH-1:0]            valid_d;
  logic [QDEPTH-1:0][IDX_W-1:0] age_d;

  // lowest free slot
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    occupied   = '0;
    for (int i = QDEPTH - 1; i >= 0; i--) begin
      if (!q_valid[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      occupied = occupied + CNT_W'(q_valid[i]);
    end
  end

  assign full = ~free_found;

  // age is a rank: 0 is the oldest entry, ranks of valid entries are distinct
  always_comb begin
    valid_d = q_valid;
    age_d   = q_age;
    if (rm_en) begin
      valid_d[rm_idx] = 1'b0;
      for (int i = 0; i < QDEPTH; i++) begin
        if (q_valid[i] && (q_age[i] > q_age[rm_idx])) begin
          age_d[i] = q_age[i] - IDX_W'(1);
        end
      end
    end
    if (ins_en) begin
      valid_d[free_idx] = 1'b1;
      age_d[free_idx]   = IDX_W'(occupied - CNT_W'(rm_en));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= '0;
      q_age   <= '0;
    end else begin
      q_valid <= valid_d;
      q_age   <= age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      q_write[free_idx] <= ins_write;
      q_bank[free_idx]  <= ins_bank;
      q_row[free_idx]   <= ins_row;
      q_col[free_idx]   <= ins_col;
    end
  end
endmodule

// File: rtl/dram_sched_bank.sv
module dram_sched_bank #(
  parameter int ROW_W = 8,
  parameter int TMR_W = 2,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_en,
  input  logic             pre_en,
  input  logic [ROW_W-1:0] act_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             idle
);
  logic [TMR_W-1:0] tmr, tmr_d;
  logic             open_d;

  always_comb begin
    tmr_d  = tmr;
    open_d = is_open;
    if (act_en) begin
      tmr_d  = TMR_W'(T_RCD);
      open_d = 1'b1;
    end else if (pre_en) begin
      tmr_d  = TMR_W'(T_RP);
      open_d = 1'b0;
    end else if (tmr != '0) begin
      tmr_d = tmr - TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr      <= '0;
      is_open  <= 1'b0;
      open_row <= '0;
    end else begin
      tmr     <= tmr_d;
      is_open <= open_d;
      if (act_en) open_row <= act_row;
    end
  end

  assign idle = (tmr == '0);
endmodule

// File: rtl/dram_sched_oldest.sv
module dram_sched_oldest #(
  parameter int QDEPTH = 8,
  parameter int IDX_W  = 3
) (
  input  logic [QDEPTH-1:0]            cand,
  input  logic [QDEPTH-1:0][IDX_W-1:0] age,
  output logic                         found,
  output logic [IDX_W-1:0]             idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (cand[i] && (!found || (age[i] < age[idx]))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dram_sched_pick.sv
module dram_sched_pick
  import dram_sched_pkg::*;
#(
  parameter int QDEPTH    = 8,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 8,
  parameter int IDX_W     = 3
) (
  input  logic [QDEPTH-1:0]                q_valid,
  input  logic [QDEPTH-1:0][BANK_W-1:0]    q_bank,
  input  logic [QDEPTH-1:0][ROW_W-1:0]     q_row,
  input  logic [QDEPTH-1:0][IDX_W-1:0]     q_age,
  input  logic [NUM_BANKS-1:0]             bank_open,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]  bank_row,
  input  logic [NUM_BANKS-1:0]             bank_idle,
  output logic                             sel_valid,
  output logic [IDX_W-1:0]                 sel_idx,
  output cmd_op_e                          sel_op
);
  logic [QDEPTH-1:0] hit_rdy, act_rdy, any_rdy;
  logic              hit_found, any_found;
  logic [IDX_W-1:0]  hit_idx, any_idx;

  always_comb begin
    for (int i = 0; i < QDEPTH; i++) begin
      hit_rdy[i] = q_valid[i] && bank_idle[q_bank[i]] && bank_open[q_bank[i]]
                   && (bank_row[q_bank[i]] == q_row[i]);
      act_rdy[i] = q_valid[i] && bank_idle[q_bank[i]] && !bank_open[q_bank[i]];
      // an idle bank always admits the next step of any request to it
      any_rdy[i] = q_valid[i] && bank_idle[q_bank[i]];
    end
  end

  dram_sched_oldest #(.QDEPTH(QDEPTH), .IDX_W(IDX_W)) u_hit (
    .cand (hit_rdy),
    .age  (q_age),
    .found(hit_found),
    .idx  (hit_idx)
  );

  dram_sched_oldest #(.QDEPTH(QDEPTH), .IDX_W(IDX_W)) u_any (
    .cand (any_rdy),
    .age  (q_age),
    .found(any_found),
    .idx  (any_idx)
  );

  always_comb begin
    sel_valid = hit_found | any_found;
    sel_idx   = hit_found ? hit_idx : any_idx;
    if (hit_found)              sel_op = OP_COL;
    else if (!any_found)        sel_op = OP_NONE;
    else if (act_rdy[any_idx])  sel_op = OP_ACT;
    else                        sel_op = OP_PRE;
  end
endmodule

// File: rtl/dram_sched.sv
module dram_sched
  import dram_sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int QDEPTH    = 8,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(QDEPTH),
  localparam int T_MAX    = (T_RCD > T_RP) ? T_RCD : T_RP,
  localparam int TMR_W    = $clog2(T_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic              cmd_write,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col
);
  logic                            full;
  logic [QDEPTH-1:0]               q_valid, q_write;
  logic [QDEPTH-1:0][BANK_W-1:0]   q_bank;
  logic [QDEPTH-1:0][ROW_W-1:0]    q_row;
  logic [QDEPTH-1:0][COL_W-1:0]    q_col;
  logic [QDEPTH-1:0][IDX_W-1:0]    q_age;
  logic [NUM_BANKS-1:0]            bank_open, bank_idle;
  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
  logic                            sel_valid, fire, ins_en;
  logic [IDX_W-1:0]                sel_idx;
  cmd_op_e                         sel_op;

  assign req_ready = ~full;
  assign ins_en    = req_valid & ~full;
  assign fire      = sel_valid & cmd_ready;

  dram_sched_queue #(
    .QDEPTH(QDEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .IDX_W(IDX_W)
  ) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_en   (ins_en),
    .ins_write(req_write),
    .ins_bank (req_bank),
    .ins_row  (req_row),
    .ins_col  (req_col),
    .rm_en    (fire && (sel_op == OP_COL)),
    .rm_idx   (sel_idx),
    .full     (full),
    .q_valid  (q_valid),
    .q_write  (q_write),
    .q_bank   (q_bank),
    .q_row    (q_row),
    .q_col    (q_col),
    .q_age    (q_age)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_this;
    assign hit_this = fire && (q_bank[sel_idx] == BANK_W'(b));
    dram_sched_bank #(
      .ROW_W(ROW_W), .TMR_W(TMR_W), .T_RCD(T_RCD), .T_RP(T_RP)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_en  (hit_this && (sel_op == OP_ACT)),
      .pre_en  (hit_this && (sel_op == OP_PRE)),
      .act_row (q_row[sel_idx]),
      .is_open (bank_open[b]),
      .open_row(bank_row[b]),
      .idle    (bank_idle[b])
    );
  end

  dram_sched_pick #(
    .QDEPTH(QDEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .IDX_W(IDX_W)
  ) u_pick (
    .q_valid  (q_valid),
    .q_bank   (q_bank),
    .q_row    (q_row),
    .q_age    (q_age),
    .bank_open(bank_open),
    .bank_row (bank_row),
    .bank_idle(bank_idle),
    .sel_valid(sel_valid),
    .sel_idx  (sel_idx),
    .sel_op   (sel_op)
  );

  assign cmd_valid = sel_valid;
  assign cmd_op    = sel_op;
  assign cmd_write = q_write[sel_idx];
  assign cmd_bank  = q_bank[sel_idx];
  assign cmd_row   = q_row[sel_idx];
  assign cmd_col   = q_col[sel_idx];
endmodule

// File: rtl/dram_sched_chk.sv
module dram_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int QDEPTH    = 8,
  parameter int ROW_W     = 8,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row
);
  logic                fire;
  int unsigned         occ;
  int unsigned         gap  [NUM_BANKS];
  logic                seen_open [NUM_BANKS];
  logic [ROW_W-1:0]    seen_row  [NUM_BANKS];

  assign fire = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= 0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        gap[b]       <= 0;
        seen_open[b] <= 1'b0;
        seen_row[b]  <= '0;
      end
    end else begin
      occ <= occ + ((req_valid && req_ready) ? 1 : 0) - ((fire && cmd_op == 2'd3) ? 1 : 0);
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (fire && cmd_bank == BANK_W'(b) && cmd_op == 2'd2) begin
          gap[b]       <= T_RCD;
          seen_open[b] <= 1'b1;
          seen_row[b]  <= cmd_row;
        end else if (fire && cmd_bank == BANK_W'(b) && cmd_op == 2'd1) begin
          gap[b]       <= T_RP;
          seen_open[b] <= 1'b0;
        end else if (gap[b] != 0) begin
          gap[b] <= gap[b] - 1;
        end
      end
    end
  end

  a_r1_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 0) |-> !cmd_valid);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == QDEPTH) |-> !req_ready);

  a_r3_col_open_row: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == 2'd3) |-> (seen_open[cmd_bank] && seen_row[cmd_bank] == cmd_row));

  a_r4_act_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == 2'd2) |-> !seen_open[cmd_bank]);

  a_r5_pre_open: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == 2'd1) |-> (seen_open[cmd_bank] && seen_row[cmd_bank] != cmd_row));

  a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (gap[cmd_bank] == 0));

  a_r8_op_code: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != 2'd0));
endmodule

bind dram_sched dram_sched_chk #(
  .NUM_BANKS(NUM_BANKS), .QDEPTH(QDEPTH), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_op   (cmd_op),
  .cmd_bank (cmd_bank),
  .cmd_row  (cmd_row)
);

// File: tb/tb_dram_sched.sv
module tb_dram_sched;
  localparam int NB = 4;
  localparam int QD = 8;
  localparam int RW = 8;
  localparam int CW = 6;
  localparam int TRCD = 3;
  localparam int TRP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, cmd_ready = 1'b0;
  logic [1:0]    req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic          req_ready, cmd_valid, cmd_write;
  logic [1:0]    cmd_op, cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;

  dram_sched #(.NUM_BANKS(NB), .QDEPTH(QD), .ROW_W(RW), .COL_W(CW), .T_RCD(TRCD), .T_RP(TRP)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_write(cmd_write),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col)
  );

  typedef struct {
    bit wr;
    int bank;
    int row;
    int col;
  } req_t;

  req_t mq[$];
  bit   m_open[NB];
  int   m_row[NB];
  int   m_tmr[NB];
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, compare, advance the model
  task automatic cycle(bit v, bit wr, int b, int r, int c, bit crdy);
    int e_idx;
    int e_op;
    bit e_rdy;
    string tag;
    req_valid = v; req_write = wr; req_bank = 2'(b);
    req_row = RW'(r); req_col = CW'(c); cmd_ready = crdy;
    #1;
    e_idx = -1; e_op = 0;
    for (int i = 0; i < mq.size(); i++) begin
      if (m_open[mq[i].bank] && m_row[mq[i].bank] == mq[i].row && m_tmr[mq[i].bank] == 0) begin
        e_idx = i; e_op = 3; break;
      end
    end
    if (e_idx < 0) begin
      for (int i = 0; i < mq.size(); i++) begin
        if (m_tmr[mq[i].bank] == 0) begin
          e_idx = i; e_op = m_open[mq[i].bank] ? 1 : 2; break;
        end
      end
    end
    e_rdy = (mq.size() < QD);
    chk(req_ready == e_rdy, "R2", "req_ready", int'(req_ready), int'(e_rdy));
    tag = (!crdy && mq.size() > 0) ? "R8" : "R6";
    chk(cmd_valid == (e_idx >= 0), tag, "cmd_valid", int'(cmd_valid), int'(e_idx >= 0));
    if (e_idx >= 0 && cmd_valid) begin
      tag = (e_op == 3) ? "R3" : (e_op == 2) ? "R4" : "R5";
      chk(int'(cmd_op) == e_op, tag, "cmd_op", int'(cmd_op), e_op);
      chk(int'(cmd_bank) == mq[e_idx].bank, "R7", "cmd_bank", int'(cmd_bank), mq[e_idx].bank);
      chk(int'(cmd_row) == mq[e_idx].row, "R7", "cmd_row", int'(cmd_row), mq[e_idx].row);
      chk(int'(cmd_col) == mq[e_idx].col, "R7", "cmd_col", int'(cmd_col), mq[e_idx].col);
      if (e_op == 3)
        chk(cmd_write == mq[e_idx].wr, "R9", "cmd_write", int'(cmd_write), int'(mq[e_idx].wr));
    end
    for (int k = 0; k < NB; k++) if (m_tmr[k] > 0) m_tmr[k]--;
    if (e_idx >= 0 && crdy) begin
      int bk;
      bk = mq[e_idx].bank;
      if (e_op == 1) begin m_open[bk] = 0; m_tmr[bk] = TRP; end
      else if (e_op == 2) begin m_open[bk] = 1; m_row[bk] = mq[e_idx].row; m_tmr[bk] = TRCD; end
      else mq.delete(e_idx);
    end
    if (v && e_rdy) begin
      req_t n;
      n.wr = wr; n.bank = b; n.row = r; n.col = c;
      mq.push_back(n);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NB; k++) begin m_open[k] = 0; m_row[k] = 0; m_tmr[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty and idle after reset
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
    // R1 / R4: first command to a fresh bank is an activate
    cycle(1, 0, 0, 5, 1, 1);
    chk(cmd_valid && cmd_op == 2'd2, "R1", "first op", int'(cmd_op), 2);
    // R3 hit, R5 conflict, R9 write flag
    cycle(1, 1, 0, 5, 2, 1);
    cycle(1, 0, 0, 7, 3, 1);
    for (int i = 0; i < 20; i++) cycle(0, 0, 0, 0, 0, 1);
    // R2: fill the queue while the command side stalls (R8)
    for (int i = 0; i < QD + 2; i++) cycle(1, i[0], i % NB, i % 3, i, 0);
    chk(req_ready == 1'b0, "R2", "req_ready when full", int'(req_ready), 0);
    for (int i = 0; i < 40; i++) cycle(0, 0, 0, 0, 0, 1);
    // R7: mixed traffic with few rows so hits and conflicts interleave
    for (int i = 0; i < 6000; i++) begin
      cycle($urandom_range(0, 2) != 0, 1'($urandom_range(0, 1)),
            int'($urandom_range(0, NB - 1)), int'($urandom_range(0, 2)),
            int'($urandom_range(0, 63)), $urandom_range(0, 3) != 0);
    end
    for (int i = 0; i < 80; i++) cycle(0, 0, 0, 0, 0, 1);
    chk(cmd_valid == 1'b0, "R8", "drained cmd_valid", int'(cmd_valid), 0);
    chk(req_ready == 1'b1, "R2", "drained req_ready", int'(req_ready), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule